// File: doc/BRIEF.md
# Thermal Sensor Code Interpolator

This block converts the raw 12-bit reading of an on-die temperature sensor into a signed temperature in millidegrees Celsius. A fixed calibration curve is held inside the block. It has one point every 5 °C from -40 °C to +125 °C, and the sensor code falls as the temperature rises. For each reading the block locates the pair of calibration points that bracket the code, using a binary search that probes the table once per cycle. It then interpolates linearly between the two points, using a restoring divider that retires one quotient bit per cycle.

A producer offers a code with a valid/ready handshake. The block holds `in_ready` low from acceptance until the result has been shown, so at most one conversion is ever in flight. The result appears as a single-cycle `out_valid` pulse. Two flags travel with the temperature. One reports a code wider than 12 bits. The other reports a zero code, which the sensor gives when no conversion is available yet.

Top module: `thermo_code_interp`

## Requirements
- R1: `in_ready` is high only while no conversion is in flight. A code is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance until the result pulse has been shown. Every accepted code yields exactly one `out_valid` pulse, one cycle wide.
- R2: For codes from 3421 to 3800, the result is T_prev + (T_cur - T_prev) * (C_prev - code) / (C_prev - C_cur). The division is truncating and unsigned. (C_cur, T_cur) is the first calibration point whose code is less than or equal to the input, and (C_prev, T_prev) is the point just before it. The result always lies in [-40000, 125000].
- R3: Calibration codes return their own temperature exactly: 3800 gives -40000, 3728 gives 0, 3600 gives 60000, 3510 gives 95000 and 3421 gives 125000.
- R4: Codes from 3801 up to 4095 give -40000, with both flags low.
- R5: Codes from 1 to 3420 give 125000, with both flags low.
- R6: A code of 4096 or more raises `out_err`. In that case `out_temp` is 0 and `out_nodata` is low.
- R7: A code of 0 raises `out_nodata`. In that case `out_temp` is 0 and `out_err` is low.
- R8: Across consecutive input codes, the temperature never rises as the code rises.
- R9: Results for error and zero codes appear in the cycle right after acceptance. All other results appear within NUM_W + 16 cycles of acceptance.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: When the code equals a calibration code, the search takes that point as the current entry. The chosen pair always satisfies C_cur <= code < C_prev, except at the top sentinel (code 4095).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | Block is idle and takes the offered code |
| in_code | input | CODE_IN_W (16) | Raw sensor code; bits above 11 must be zero |
| out_valid | output | 1 | One-cycle result pulse |
| out_temp | output | TEMP_W (32) | Signed temperature in millidegrees Celsius |
| out_err | output | 1 | Code wider than 12 bits |
| out_nodata | output | 1 | Zero code: no conversion available |

## Verification
The bench builds the block with a 16-bit input, so codes above 0xFFF can be driven and the error path is reached. It uses the default 24-bit divider, which places the latency bound at 40 cycles. An unbroken sweep from code 3400 to 3820 crosses every calibration point and both clamp regions, checking each result and the ordering of the whole curve. Holding `in_valid` high between codes exercises the rule that only one conversion is in flight at a time.

// File: rtl/thermo_interp_pkg.sv
package thermo_interp_pkg;

   // Curve shape: points on a fixed step, codes falling with temperature
   localparam int CAL_POINTS    = 34;
   localparam int TAB_ENTRIES   = CAL_POINTS + 2;   // plus a sentinel at each end
   localparam int TEMP_FLOOR_MC = -40000;
   localparam int TEMP_STEP_MC  = 5000;
   localparam int CODE_TOP      = 4095;
   localparam int RAW_CODE_W    = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEARCH,
      ST_SCALE,
      ST_DIVIDE,
      ST_DONE
   } interp_state_e;

   // Code at calibration point n (n = 0 is the coldest point)
   function automatic int cal_code(input int n);
      case (n)
         0:  cal_code = 3800;  1:  cal_code = 3792;  2:  cal_code = 3783;
         3:  cal_code = 3774;  4:  cal_code = 3765;  5:  cal_code = 3756;
         6:  cal_code = 3747;  7:  cal_code = 3737;  8:  cal_code = 3728;
         9:  cal_code = 3718;  10: cal_code = 3708;  11: cal_code = 3698;
         12: cal_code = 3688;  13: cal_code = 3678;  14: cal_code = 3667;
         15: cal_code = 3656;  16: cal_code = 3645;  17: cal_code = 3634;
         18: cal_code = 3623;  19: cal_code = 3611;  20: cal_code = 3600;
         21: cal_code = 3588;  22: cal_code = 3575;  23: cal_code = 3563;
         24: cal_code = 3550;  25: cal_code = 3537;  26: cal_code = 3524;
         27: cal_code = 3510;  28: cal_code = 3496;  29: cal_code = 3482;
         30: cal_code = 3467;  31: cal_code = 3452;  32: cal_code = 3437;
         default: cal_code = 3421;
      endcase
   endfunction

   // Table entry code, sentinels included (entry 0 = top, last = zero)
   function automatic int tab_code(input int idx);
      if (idx <= 0)                     tab_code = CODE_TOP;
      else if (idx >= TAB_ENTRIES - 1)  tab_code = 0;
      else                              tab_code = cal_code(idx - 1);
   endfunction

   // Table entry temperature; sentinels repeat their neighbour
   function automatic int tab_temp(input int idx);
      if (idx <= 1)                     tab_temp = TEMP_FLOOR_MC;
      else if (idx >= TAB_ENTRIES - 2)  tab_temp = TEMP_FLOOR_MC + TEMP_STEP_MC * (CAL_POINTS - 1);
      else                              tab_temp = TEMP_FLOOR_MC + TEMP_STEP_MC * (idx - 1);
   endfunction

endpackage

// File: rtl/thermo_cal_rom.sv
module thermo_cal_rom
   import thermo_interp_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int CODE_W = 12,
   parameter int TEMP_W = 32
) (
   input  logic [IDX_W-1:0]         idx,
   output logic [CODE_W-1:0]        code,
   output logic signed [TEMP_W-1:0] temp
);

   if ((1 << IDX_W) < TAB_ENTRIES) begin : g_bad_idx
      $error("thermo_cal_rom: IDX_W too narrow for the table");
   end

   always_comb begin
      code = CODE_W'(tab_code(int'(idx)));
      temp = TEMP_W'(tab_temp(int'(idx)));
   end

endmodule

// File: rtl/thermo_bracket_search.sv
module thermo_bracket_search
   import thermo_interp_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int IDX_W  = 6,
   parameter int TEMP_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] code,
   output logic              busy,
   output logic              done,
   output logic [IDX_W-1:0]  hit_idx
);

   localparam logic [IDX_W-1:0] LO_INIT = IDX_W'(1);
   localparam logic [IDX_W-1:0] HI_INIT = IDX_W'(TAB_ENTRIES - 1);

   logic [IDX_W-1:0]        lo_q, hi_q, mid;
   logic [IDX_W:0]          span_sum;
   logic [CODE_W-1:0]       code_q;
   logic [CODE_W-1:0]       probe_code;
   logic signed [TEMP_W-1:0] probe_temp;

   assign span_sum = {1'b0, lo_q} + {1'b0, hi_q};
   assign mid      = span_sum[IDX_W:1];

   thermo_cal_rom #(.IDX_W(IDX_W), .CODE_W(CODE_W), .TEMP_W(TEMP_W)) u_probe (
      .idx  (mid),
      .code (probe_code),
      .temp (probe_temp)
   );

   // Find the lowest index whose code does not exceed the input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= LO_INIT;
         hi_q    <= HI_INIT;
         code_q  <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         hit_idx <= LO_INIT;
      end else begin
         done <= 1'b0;
         if (start) begin
            lo_q   <= LO_INIT;
            hi_q   <= HI_INIT;
            code_q <= code;
            busy   <= 1'b1;
         end else if (busy) begin
            if (lo_q < hi_q) begin
               if (probe_code <= code_q) hi_q <= mid;
               else                      lo_q <= mid + IDX_W'(1);
            end else begin
               busy    <= 1'b0;
               done    <= 1'b1;
               hit_idx <= lo_q;
            end
         end
      end
   end

   assert_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (lo_q <= hi_q && lo_q >= LO_INIT));

   assert_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (hit_idx >= LO_INIT && hit_idx <= HI_INIT));

endmodule

// File: rtl/thermo_restoring_div.sv
module thermo_restoring_div #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] dividend,
   input  logic [DEN_W-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quotient
);

   localparam int CNT_W = $clog2(NUM_W + 1);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_W - 1);

   if (NUM_W < 2) begin : g_bad_num
      $error("thermo_restoring_div: NUM_W must be at least 2");
   end

   logic [DEN_W:0]   rem_q, shifted, trial;
   logic [DEN_W-1:0] div_q;
   logic [NUM_W-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fits;

   assign shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
   assign trial   = shifted - {1'b0, div_q};
   assign fits    = shifted >= {1'b0, div_q};
   assign quotient = quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         div_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem_q <= '0;
            div_q <= divisor;
            quo_q <= dividend;
            cnt_q <= '0;
            busy  <= 1'b1;
         end else if (busy) begin
            rem_q <= fits ? trial : shifted;
            quo_q <= {quo_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == LAST_STEP) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assert_den_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (divisor != '0));

   assert_remainder_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem_q < {1'b0, div_q}));

endmodule

// File: rtl/thermo_code_interp.sv
module thermo_code_interp
   import thermo_interp_pkg::*;
#(
   parameter int CODE_IN_W = 16,
   parameter int TEMP_W    = 32,
   parameter int NUM_W     = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [CODE_IN_W-1:0]     in_code,
   output logic                     out_valid,
   output logic signed [TEMP_W-1:0] out_temp,
   output logic                     out_err,
   output logic                     out_nodata
);

   localparam int CODE_W    = RAW_CODE_W;
   localparam int IDX_W     = $clog2(TAB_ENTRIES);
   localparam int LAT_BOUND = NUM_W + 16;
   localparam int LAT_W     = $clog2(LAT_BOUND + 2);

   if (CODE_IN_W < CODE_W) begin : g_bad_in
      $error("thermo_code_interp: CODE_IN_W below the raw code width");
   end
   if (TEMP_W < 18) begin : g_bad_temp
      $error("thermo_code_interp: TEMP_W cannot hold the range");
   end
   if (NUM_W < 18) begin : g_bad_num
      $error("thermo_code_interp: NUM_W cannot hold step times gap");
   end

   interp_state_e state_q;
   logic accept, in_over, in_zero;
   logic [CODE_W-1:0] code_q;
   logic [IDX_W-1:0]  idx_q;
   logic signed [TEMP_W-1:0] base_q;

   // Width check on the incoming code
   if (CODE_IN_W > CODE_W) begin : g_over_wide
      assign in_over = |in_code[CODE_IN_W-1:CODE_W];
   end else begin : g_over_none
      assign in_over = 1'b0;
   end

   assign in_zero  = (in_code[CODE_W-1:0] == '0) && !in_over;
   assign in_ready = (state_q == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign out_valid = (state_q == ST_DONE);

   // Bracket search
   logic             srch_start, srch_busy, srch_done;
   logic [IDX_W-1:0] srch_idx;

   assign srch_start = accept && !in_over && !in_zero;

   thermo_bracket_search #(.CODE_W(CODE_W), .IDX_W(IDX_W), .TEMP_W(TEMP_W)) u_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (srch_start),
      .code    (in_code[CODE_W-1:0]),
      .busy    (srch_busy),
      .done    (srch_done),
      .hit_idx (srch_idx)
   );

   // Lookup of the current (0) and preceding (1) table entries
   logic [CODE_W-1:0]        pt_code [2];
   logic signed [TEMP_W-1:0] pt_temp [2];

   for (genvar g = 0; g < 2; g++) begin : g_pt
      logic [IDX_W-1:0] pt_idx;
      assign pt_idx = idx_q - IDX_W'(g);
      thermo_cal_rom #(.IDX_W(IDX_W), .CODE_W(CODE_W), .TEMP_W(TEMP_W)) u_rom (
         .idx  (pt_idx),
         .code (pt_code[g]),
         .temp (pt_temp[g])
      );
   end

   // Scale and divide
   logic [TEMP_W-1:0] t_gap;
   logic [CODE_W-1:0] c_gap, c_span;
   logic [NUM_W-1:0]  dividend, quotient;
   logic              div_start, div_busy, div_done;

   assign t_gap     = pt_temp[0] - pt_temp[1];
   assign c_gap     = pt_code[1] - code_q;
   assign c_span    = pt_code[1] - pt_code[0];
   assign dividend  = NUM_W'(t_gap) * NUM_W'(c_gap);
   assign div_start = (state_q == ST_SCALE);

   thermo_restoring_div #(.NUM_W(NUM_W), .DEN_W(CODE_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (dividend),
      .divisor  (c_span),
      .busy     (div_busy),
      .done     (div_done),
      .quotient (quotient)
   );

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         code_q     <= '0;
         idx_q      <= IDX_W'(1);
         base_q     <= '0;
         out_temp   <= '0;
         out_err    <= 1'b0;
         out_nodata <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  out_err    <= in_over;
                  out_nodata <= in_zero;
                  out_temp   <= '0;
                  code_q     <= in_code[CODE_W-1:0];
                  state_q    <= (in_over || in_zero) ? ST_DONE : ST_SEARCH;
               end
            end
            ST_SEARCH: begin
               if (srch_done) begin
                  idx_q   <= srch_idx;
                  state_q <= ST_SCALE;
               end
            end
            ST_SCALE: begin
               base_q  <= pt_temp[1];
               state_q <= ST_DIVIDE;
            end
            ST_DIVIDE: begin
               if (div_done) begin
                  out_temp <= base_q + TEMP_W'(quotient);
                  state_q  <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Latency watch for the checks below
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lat_q <= '0;
      else if (accept)            lat_q <= LAT_W'(1);
      else if (state_q != ST_IDLE && lat_q != '1) lat_q <= lat_q + LAT_W'(1);
   end

   assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   assert_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_temp == '0 && !out_nodata));

   assert_nodata_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_nodata) |-> (out_temp == '0 && !out_err));

   assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err && !out_nodata) |->
         (out_temp >= TEMP_W'(TEMP_FLOOR_MC) &&
          out_temp <= TEMP_W'(TEMP_FLOOR_MC + TEMP_STEP_MC * (CAL_POINTS - 1))));

   assert_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_over || in_code[CODE_W-1:0] == '0)) |=> out_valid);

   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (int'(lat_q) <= LAT_BOUND));

   assert_bracket_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SCALE) |->
         (pt_code[0] <= code_q && (code_q < pt_code[1] || code_q == CODE_W'(CODE_TOP))));

   assert_engines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (!srch_busy && !div_busy));

endmodule

// File: tb/tb_thermo_code_interp.sv
module tb_thermo_code_interp;

   localparam int CODE_IN_W = 16;
   localparam int TEMP_W    = 32;
   localparam int NUM_W     = 24;
   localparam int LAT_MAX   = NUM_W + 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [CODE_IN_W-1:0] in_code = '0;
   logic out_valid;
   logic signed [TEMP_W-1:0] out_temp;
   logic out_err, out_nodata;

   always #10 clk = ~clk;   // 50 MHz

   thermo_code_interp #(.CODE_IN_W(CODE_IN_W), .TEMP_W(TEMP_W), .NUM_W(NUM_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_code(in_code), .out_valid(out_valid), .out_temp(out_temp),
      .out_err(out_err), .out_nodata(out_nodata)
   );

   int checks = 0;
   int failures = 0;

   typedef struct {
      int    code;
      int    exp_t;
      bit    exp_e;
      bit    exp_n;
      bit    sweep;
      string req;
   } item_t;

   item_t exp_q[$];

   // Calibration curve from the requirements, coldest point first
   int cal[34] = '{3800,3792,3783,3774,3765,3756,3747,3737,3728,3718,3708,3698,
                   3688,3678,3667,3656,3645,3634,3623,3611,3600,3588,3575,3563,
                   3550,3537,3524,3510,3496,3482,3467,3452,3437,3421};

   function automatic int ref_temp(input int code);
      if (code >= cal[0]) return -40000;
      if (code < cal[33]) return 125000;
      for (int j = 1; j < 34; j++) begin
         if (code >= cal[j] && code < cal[j-1])
            return -40000 + 5000 * (j - 1) + (5000 * (cal[j-1] - code)) / (cal[j-1] - cal[j]);
      end
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Driver: queue the expectation, then offer the code until taken
   task automatic send(input int code, input bit sweep, input string req);
      item_t it;
      it.code  = code;
      it.exp_e = (code > 4095);
      it.exp_n = (code == 0);
      it.exp_t = (it.exp_e || it.exp_n) ? 0 : ref_temp(code);
      it.sweep = sweep;
      it.req   = req;
      @(negedge clk);
      exp_q.push_back(it);
      in_code  = CODE_IN_W'(code);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
   endtask

   // Acceptance tracker, read before the edge updates land
   int cyc = 0;
   int acc_cyc = 0;
   bit busy_tb = 1'b0;
   always @(posedge clk) begin
      if (rst_n && in_valid && in_ready) begin
         acc_cyc = cyc;
         busy_tb = 1'b1;
      end
      cyc = cyc + 1;
   end

   // Monitor / scoreboard
   int  prev_sweep_t = 0;
   bit  have_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "unexpected result", 1, 0);
            end else begin
               item_t it;
               int lat;
               it  = exp_q.pop_front();
               lat = cyc - acc_cyc;
               check(out_temp == it.exp_t, it.req, $sformatf("temp code=%0d", it.code),
                     out_temp, it.exp_t);
               check(out_err == it.exp_e, it.exp_e ? "R6" : it.req,
                     $sformatf("err code=%0d", it.code), out_err, it.exp_e);
               check(out_nodata == it.exp_n, it.exp_n ? "R7" : it.req,
                     $sformatf("nodata code=%0d", it.code), out_nodata, it.exp_n);
               if (it.exp_e || it.exp_n)
                  check(lat == 1, "R9", "fast latency", lat, 1);
               else
                  check(lat <= LAT_MAX, "R9", "latency", lat, LAT_MAX);
               if (it.sweep) begin
                  if (have_prev)
                     check(out_temp <= prev_sweep_t, "R8", "ordering", out_temp, prev_sweep_t);
                  prev_sweep_t = out_temp;
                  have_prev = 1'b1;
               end
            end
            busy_tb = 1'b0;
         end else if (busy_tb && in_ready) begin
            check(1'b0, "R1", "ready while busy", 1, 0);
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
      check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

      // Calibration points and search ties
      send(3728, 0, "R3");
      send(3600, 0, "R3");
      send(3510, 0, "R3");
      send(3800, 0, "R11");
      send(3421, 0, "R11");
      send(3437, 0, "R11");
      // Interpolated values
      send(3700, 0, "R2");
      send(3425, 0, "R2");
      send(3799, 0, "R2");
      // Clamps
      send(3801, 0, "R4");
      send(4095, 0, "R4");
      send(3420, 0, "R5");
      send(1,    0, "R5");
      // Error and empty codes, back to back with normal ones
      send(4096, 0, "R6");
      send(65535, 0, "R6");
      send(0,    0, "R7");
      send(3650, 0, "R2");
      send(0,    0, "R7");
      // Full sweep across both clamps
      for (int c = 3400; c <= 3820; c++) send(c, 1, "R2");

      @(negedge clk);
      in_valid = 1'b0;
      for (int w = 0; w < 200 && (exp_q.size() != 0 || busy_tb); w++) @(negedge clk);
      check(exp_q.size() == 0, "R1", "results outstanding", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule